// File: doc/BRIEF.md
# Vectored Interrupt Controller with Global Enable

This block gathers three interrupt sources for a small processor core. The first is an edge on an external interrupt pin, rising or falling as selected by software. The second is a change on any line of a narrow group of port inputs, measured against a copy that is latched when the core reads the port. The third is a single-cycle overflow pulse from a timer. Each source owns a sticky flag and an enable bit, and one global enable bit gates all of them. Flags, enables, the edge polarity and the global enable sit in one 8-bit control register that the core writes as a whole and can always read back.

At an instruction boundary the block checks for a pending request: the global enable is set and some flag is set whose enable is also set. If there is one, it starts a forced call that lasts two cycles. During the call the vector output shows the interrupt entry address. At all other times it shows the reset address. Taking the call clears the global enable, and a return-from-interrupt strobe sets it again. The core pushes only the return address. The block saves no other context.

Hardware only ever sets flags, and it does so whether or not the source is enabled. Only a software write clears them. A flag that is still set after the return therefore raises a new request at the next boundary.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the control register reads 8'h00, `irq_call_o` is 0 and `vec_o` equals the reset address (0x000).
- R2: Control register bit 6 selects the polarity of the external pin edge: 1 = rising, 0 = falling. An edge of the selected kind on the synchronised pin sets flag bit 0. An edge of the other kind does not.
- R3: Flag bit 1 is set in every cycle in which the synchronised port inputs differ from the latched copy. A `port_rd_i` strobe loads the synchronised value into the latched copy. `port_val_o` shows the synchronised port value.
- R4: A pulse on `tmr_ovf_i` sets flag bit 2.
- R5: Flags (bits 2:0) are set by their events regardless of the enable bits (bits 5:3) and stay set until software writes 0 to them. When an event and a clearing write fall in the same cycle, the flag ends up set.
- R6: A request is taken when bit 7 (global enable) is 1, some flag is 1 and its enable is 1, and `insn_bnd_i` is high. `irq_call_o` is then high for exactly the two following cycles, and `vec_o` reads 0x004 during them.
- R7: Taking a request clears the global enable, even if a write to set bit 7 arrives in the same cycle.
- R8: A `reti_i` strobe sets the global enable in the following cycle.
- R9: A flag left set after the return raises a new call at the next instruction boundary.
- R10: No call starts when the global enable is 0, when the pending flag's enable is 0, or when there is no instruction boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 1 | External interrupt pin (asynchronous) |
| port_i | input | PORT_W | Port input group watched for change (asynchronous) |
| tmr_ovf_i | input | 1 | Timer overflow pulse, one cycle |
| port_rd_i | input | 1 | Port read strobe, updates the latched copy |
| port_val_o | output | PORT_W | Synchronised port value |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Write data: [7] global enable, [6] rising edge, [5:3] enables, [2:0] flags |
| rd_data_o | output | 8 | Control register contents, same layout as the write data |
| insn_bnd_i | input | 1 | High at an instruction boundary |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_call_o | output | 1 | Forced call in progress |
| vec_o | output | VEC_W | Interrupt entry address during a call, reset address otherwise |

## Verification
The bench builds the block with its defaults: four port lines, a two-stage synchroniser and a two-cycle call. With these values, every edge and change reaches its flag three clock edges after the input moves, so the reference model can follow each cycle exactly. The call is also short enough that a return, a second boundary and a clash between a take and a write to the global enable can all be placed a few cycles apart. The port width of four lets a change on a subset of the lines, and a read that resolves it, be exercised directly.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned NSRC     = 3;
    localparam int unsigned SRC_PIN  = 0;
    localparam int unsigned SRC_PORT = 1;
    localparam int unsigned SRC_TMR  = 2;

    typedef struct packed {
        logic            ge;
        logic            rise;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] flag;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = d_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign q_o = s_q.chain[STAGES-1];
endmodule

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic evt_o
);
    logic pin_s;
    logic prev_d, prev_q;

    irq_sync #(.W(1), .STAGES(SYNC_STAGES)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_i),
        .q_o    (pin_s)
    );

    always_comb begin
        prev_d = pin_s;
        evt_o  = rise_sel_i ? (pin_s & ~prev_q) : (~pin_s & prev_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end

    // R2: an event means the synchronised pin moved since the last cycle
    a_r2_evt_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o |-> (pin_s != prev_q));
endmodule

// File: rtl/irq_port_chg.sv
module irq_port_chg #(
    parameter int unsigned PORT_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PORT_W-1:0] port_i,
    input  logic              rd_i,
    output logic [PORT_W-1:0] val_o,
    output logic              evt_o
);
    logic [PORT_W-1:0] port_s;
    logic [PORT_W-1:0] latch_d, latch_q;

    irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (port_i),
        .q_o    (port_s)
    );

    always_comb begin
        latch_d = rd_i ? port_s : latch_q;
        evt_o   = |(port_s ^ latch_q);
        val_o   = port_s;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) latch_q <= '0;
        else         latch_q <= latch_d;
    end

    // R3: after a read the copy holds the value seen at the read
    a_r3_read_loads_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_i |=> (latch_q == $past(port_s)));
endmodule

// File: rtl/irq_flag_core.sv
module irq_flag_core import irq_pkg::*; (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] evt_i,
    input  logic            wr_en_i,
    input  ctrl_t           wr_data_i,
    input  logic            insn_bnd_i,
    input  logic            reti_i,
    output ctrl_t           ctrl_o,
    output logic            take_o
);
    ctrl_t ctrl_d, ctrl_q;
    logic  pend;

    always_comb begin
        pend   = |(ctrl_q.flag & ctrl_q.en);
        take_o = ctrl_q.ge & pend & insn_bnd_i;
        ctrl_d = wr_en_i ? wr_data_i : ctrl_q;
        ctrl_d.flag = ctrl_d.flag | evt_i;
        if (take_o)       ctrl_d.ge = 1'b0;
        else if (reti_i)  ctrl_d.ge = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctrl_q <= '0;
        else         ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

    // R5: without a write no flag is ever lost
    a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> ((ctrl_q.flag & $past(ctrl_q.flag)) == $past(ctrl_q.flag)));
    // R5: an event always leaves its flag set
    a_r5_evt_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> ((ctrl_q.flag & $past(evt_i)) == $past(evt_i)));
    // R7: a take always leaves the global enable clear
    a_r7_take_drops_ge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |=> !ctrl_q.ge);
    // R8: a return without a take re-arms the global enable
    a_r8_reti_sets_ge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reti_i && !take_o) |=> ctrl_q.ge);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl import irq_pkg::*; #(
    parameter int unsigned PORT_W      = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned VEC_W       = 13,
    parameter logic [VEC_W-1:0] IRQ_VEC = 13'h004,
    parameter logic [VEC_W-1:0] RST_VEC = 13'h000,
    parameter int unsigned CALL_CYCLES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ext_pin_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic              tmr_ovf_i,
    input  logic              port_rd_i,
    output logic [PORT_W-1:0] port_val_o,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [CTRL_W-1:0] rd_data_o,
    input  logic              insn_bnd_i,
    input  logic              reti_i,
    output logic              irq_call_o,
    output logic [VEC_W-1:0]  vec_o
);
    localparam int unsigned CNT_W = $clog2(CALL_CYCLES + 1);

    logic [NSRC-1:0] evt;
    ctrl_t           ctrl;
    logic            take;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } call_t;

    call_t call_d, call_q;

    irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) i_pin_edge (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_i      (ext_pin_i),
        .rise_sel_i (ctrl.rise),
        .evt_o      (evt[SRC_PIN])
    );

    irq_port_chg #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) i_port_chg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .port_i (port_i),
        .rd_i   (port_rd_i),
        .val_o  (port_val_o),
        .evt_o  (evt[SRC_PORT])
    );

    assign evt[SRC_TMR] = tmr_ovf_i;

    irq_flag_core i_flag_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_i      (evt),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (ctrl_t'(wr_data_i)),
        .insn_bnd_i (insn_bnd_i),
        .reti_i     (reti_i),
        .ctrl_o     (ctrl),
        .take_o     (take)
    );

    always_comb begin
        call_d = call_q;
        if (take)                call_d.cnt = CNT_W'(CALL_CYCLES);
        else if (call_q.cnt != 0) call_d.cnt = call_q.cnt - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) call_q <= '0;
        else         call_q <= call_d;
    end

    assign irq_call_o = (call_q.cnt != 0);
    assign vec_o      = irq_call_o ? IRQ_VEC : RST_VEC;
    assign rd_data_o  = ctrl;

    // R6: a call that starts lasts at least a second cycle
    a_r6_call_two_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_call_o && !$past(irq_call_o)) |=> irq_call_o);
    // R7: a fresh call always finds the global enable already cleared
    a_r7_call_ge_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_call_o && !$past(irq_call_o)) |-> !ctrl.ge);
endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
    localparam int S = 2;
    localparam int PERIOD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0;
    logic [3:0] port = 4'h0;
    logic       tmr = 1'b0;
    logic       port_rd = 1'b0;
    logic [3:0] port_val;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       insn_bnd = 1'b0;
    logic       reti = 1'b0;
    logic       irq_call;
    logic [12:0] vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    irq_ctrl i_irq_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ext_pin_i  (ext_pin),
        .port_i     (port),
        .tmr_ovf_i  (tmr),
        .port_rd_i  (port_rd),
        .port_val_o (port_val),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .rd_data_o  (rd_data),
        .insn_bnd_i (insn_bnd),
        .reti_i     (reti),
        .irq_call_o (irq_call),
        .vec_o      (vec)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model
    bit       e_hist[$];
    bit [3:0] p_hist[$];
    bit       m_prev, m_ge, m_rise;
    bit [2:0] m_en, m_flag;
    bit [3:0] m_latch;
    int       m_cnt;

    task automatic model_reset();
        e_hist.delete(); p_hist.delete();
        for (int i = 0; i < S; i++) begin
            e_hist.push_back(1'b0);
            p_hist.push_back(4'h0);
        end
        m_prev = 0; m_ge = 0; m_rise = 0; m_en = 0; m_flag = 0;
        m_latch = 0; m_cnt = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        bit cur_e, pin_evt, chg_evt, take;
        bit [3:0] cur_p;
        bit [2:0] f;
        if (!rst_n) begin
            model_reset();
        end else begin
            cur_e = e_hist[e_hist.size() - S];
            cur_p = p_hist[p_hist.size() - S];
            pin_evt = m_rise ? (cur_e && !m_prev) : (!cur_e && m_prev);
            chg_evt = (cur_p != m_latch);
            take = m_ge && ((m_flag & m_en) != 0) && insn_bnd;
            f = wr_en ? wr_data[2:0] : m_flag;
            f = f | {tmr, chg_evt, pin_evt};
            m_flag = f;
            if (wr_en) begin
                m_en = wr_data[5:3];
                m_rise = wr_data[6];
            end
            if (take) m_ge = 0;
            else if (reti) m_ge = 1;
            else if (wr_en) m_ge = wr_data[7];
            if (take) m_cnt = 2;
            else if (m_cnt > 0) m_cnt--;
            if (port_rd) m_latch = cur_p;
            m_prev = cur_e;
            e_hist.push_back(ext_pin);
            p_hist.push_back(port);
            if (e_hist.size() > S + 2) begin
                void'(e_hist.pop_front());
                void'(p_hist.pop_front());
            end
        end
        #2;
        check("R5 control register", rd_data, {m_ge, m_rise, m_en, m_flag});
        check("R6 call strobe", irq_call, (m_cnt != 0));
        check("R6 vector", vec, (m_cnt != 0) ? 4 : 0);
        check("R3 port value", port_val, p_hist[p_hist.size() - S]);
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic write(logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic boundary();
        insn_bnd = 1'b1;
        step();
        insn_bnd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=end of sequence");
        finish_run();
    end

    initial begin
        step(2);
        // R1 reset state
        check("R1 reset register", rd_data, 8'h00);
        check("R1 reset call", irq_call, 0);
        check("R1 reset vector", vec, 0);
        rst_n = 1'b1;
        step(2);

        // R2 rising polarity
        write(8'h40);
        ext_pin = 1'b1; step(5);
        check("R2 rising edge sets flag", rd_data[0], 1);
        write(8'h40);
        ext_pin = 1'b0; step(5);
        check("R2 falling edge ignored in rising mode", rd_data[0], 0);
        // R2 falling polarity
        write(8'h00);
        ext_pin = 1'b1; step(5);
        check("R2 rising edge ignored in falling mode", rd_data[0], 0);
        ext_pin = 1'b0; step(5);
        check("R2 falling edge sets flag", rd_data[0], 1);

        // R3 port change
        write(8'h00);
        port = 4'b0101; step(5);
        check("R3 change sets flag", rd_data[1], 1);
        check("R3 port value visible", port_val, 4'b0101);
        write(8'h00); step(2);
        check("R3 unread change re-sets flag", rd_data[1], 1);
        port_rd = 1'b1; step(); port_rd = 1'b0;
        write(8'h00); step(3);
        check("R3 read resolves change", rd_data[1], 0);
        port = 4'b0111; step(5);
        check("R3 single line change sets flag", rd_data[1], 1);
        port_rd = 1'b1; step(); port_rd = 1'b0;
        write(8'h00); step(2);

        // R4 timer, R5 regardless of enable
        tmr = 1'b1; step(); tmr = 1'b0;
        check("R4 overflow sets flag", rd_data[2], 1);
        check("R5 flag set with enable clear", rd_data, 8'h04);
        step(3);
        check("R5 flag sticky", rd_data, 8'h04);
        wr_en = 1'b1; wr_data = 8'h00; tmr = 1'b1;
        step();
        wr_en = 1'b0; tmr = 1'b0;
        check("R5 event wins over clear", rd_data[2], 1);

        // R10 enabled but no boundary
        write(8'hA4); step(3);
        check("R10 no call without boundary", irq_call, 0);
        // R6 take
        boundary();
        check("R6 call first cycle", irq_call, 1);
        check("R6 vector during call", vec, 4);
        check("R7 take clears global enable", rd_data[7], 0);
        step();
        check("R6 call second cycle", irq_call, 1);
        step();
        check("R6 call ends after two cycles", irq_call, 0);
        check("R6 vector back to reset address", vec, 0);

        // R8 return, R9 re-entry on uncleared flag
        reti = 1'b1; step(); reti = 1'b0;
        check("R8 return sets global enable", rd_data[7], 1);
        boundary();
        check("R9 uncleared flag re-enters", irq_call, 1);
        step(2);

        // R7 take beats a write of the global enable
        reti = 1'b1; step(); reti = 1'b0;
        insn_bnd = 1'b1; wr_en = 1'b1; wr_data = 8'hA4;
        step();
        insn_bnd = 1'b0; wr_en = 1'b0;
        check("R7 take beats enable write", rd_data[7], 0);
        check("R7 call started", irq_call, 1);
        step(2);

        // R10 disabled source, and global enable low
        write(8'h84);
        boundary();
        check("R10 no call with source disabled", irq_call, 0);
        step();
        check("R10 still no call", irq_call, 0);
        write(8'h24);
        boundary();
        check("R10 no call with global enable low", irq_call, 0);
        step(3);
        finish_run();
    end
endmodule